// File: doc/BRIEF.md
# USB IN Endpoint Transmit Buffer

This block holds outgoing packets for one device-side IN endpoint and decides how to answer each IN token. Firmware loads a packet one byte at a time and then arms it. The protocol engine reports token, frame-start, handshake and end-of-transmission events as one-cycle pulses. One cycle after each IN token the block returns a response code. While a data packet is being sent, the engine reads the payload through a byte port.

Storage is one RAM split into two equal halves. In single-buffer mode one half is used. In double-buffer mode the two halves alternate: firmware fills one half while the other waits or is being sent. Both bulk/interrupt and isochronous transfer types are supported, together with stall, flush, toggle-clear, forced toggling, automatic arming at the maximum packet size and an isochronous hold-until-frame-start option.

Top module: `usb_in_ep_buf`

## Requirements
- R1: After reset `pkt_rdy`, `pkt_present`, `sent_stall`, `underrun`, `irq` and `rsp_valid` are all 0.
- R2: In single-buffer mode an arm sets `pkt_rdy` and `pkt_present`. Bulk traffic only: an ACK for the packet in flight clears both bits and pulses `irq` high for exactly one cycle. During a data response, `tx_len` is the loaded byte count and `tx_data` is the first loaded byte.
- R3: In double-buffer mode, arming while no packet is held leaves `pkt_rdy` at 0 and sets `pkt_present`. Arming while one packet is held sets `pkt_rdy`. Each completion clears `pkt_rdy`. Packets go out in the order they were loaded. `pkt_rdy` is never 1 while `pkt_present` is 0.
- R4: With auto-arm on, a packet arms itself when the byte written makes the count equal to `cfg_maxp`×8. A shorter packet stays unarmed.
- R5: Each flush discards the oldest held packet. Two flushes empty a buffer holding two packets.
- R6: In bulk/interrupt mode with `cfg_stall` high, an IN token is answered STALL. The same edge sets `sent_stall` and empties the buffer. `sent_stall` stays set until cleared by firmware. Once `cfg_stall` is low, tokens are answered normally.
- R7: When no packet is held, an IN token is answered NAK in bulk/interrupt mode and zero-length in isochronous mode. In both cases `underrun` is set and stays set until cleared by firmware.
- R8: In isochronous mode with `cfg_wait_sof` high, a token arriving before a frame-start has been seen since the packet was armed is answered zero-length and does not set `underrun`. After such a frame-start the packet is sent.
- R9: In bulk/interrupt mode without forced toggle, the toggle advances only on ACK. A token with no intervening ACK resends the same packet with the same PID. A toggle-clear makes the next data PID DATA0.
- R10: With forced toggle on, a packet completes at `ev_tx_done` without an ACK, and the next data PID is the opposite one.
- R11: Isochronous data always uses DATA0, completes at `ev_tx_done`, and leaves the bulk toggle unchanged.
- R12: `rsp_valid` is high exactly in the cycle after each `ev_in_tok`. The `rsp_code` values are: 1 DATA0, 2 DATA1, 3 zero-length, 4 NAK, 5 STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_wr_en | input | 1 | Load one byte into the filling half |
| fw_wr_data | input | 8 | Byte to load |
| fw_arm | input | 1 | Arm the packet being filled |
| fw_flush | input | 1 | Discard the oldest held packet and restart the fill pointer |
| fw_clr_tog | input | 1 | Reset the data toggle to DATA0 |
| fw_clr_sent_stall | input | 1 | Clear `sent_stall` |
| fw_clr_underrun | input | 1 | Clear `underrun` |
| cfg_stall | input | 1 | Answer IN tokens with STALL (bulk/interrupt) |
| cfg_iso | input | 1 | Isochronous transfer type |
| cfg_wait_sof | input | 1 | Isochronous: hold the packet until a frame-start |
| cfg_force_tog | input | 1 | Toggle after each send without waiting for ACK |
| cfg_auto_arm | input | 1 | Arm automatically at maximum packet size |
| cfg_dbl | input | 1 | Double-buffer mode |
| cfg_maxp | input | 8 | Maximum packet size in units of 8 bytes |
| ev_in_tok | input | 1 | IN token received |
| ev_sof | input | 1 | Frame-start received |
| ev_ack | input | 1 | ACK handshake received |
| ev_tx_done | input | 1 | Data packet fully transmitted |
| tx_rd | input | 1 | Advance the payload read pointer |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 3 | Response to the last IN token |
| tx_len | output | 7 | Byte count of the packet to send |
| tx_data | output | 8 | Current payload byte |
| pkt_rdy | output | 1 | Packet-ready: no free half for firmware |
| pkt_present | output | 1 | At least one packet held |
| sent_stall | output | 1 | A STALL was sent |
| underrun | output | 1 | Token answered with no packet available |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest states to reach are those where the buffer holds two packets and a second event acts on them. Examples are a flush that must drop the older packet and not the newer one, and an ACK that must clear `pkt_rdy` while `pkt_present` stays high. The stimulus reaches these states by arming two packets with distinct first bytes and lengths. It then issues flushes or tokens and checks each response's PID, length and first byte against a queue of expected responses. The isochronous frame-start hold is reached by arming first and sending a token before any frame-start pulse.

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fw_wr_en,
  input  logic [DW-1:0] fw_wr_data,
  input  logic          fw_arm,
  input  logic          fw_flush,
  input  logic          fw_clr_tog,
  input  logic          fw_clr_sent_stall,
  input  logic          fw_clr_underrun,
  input  logic          cfg_stall,
  input  logic          cfg_iso,
  input  logic          cfg_wait_sof,
  input  logic          cfg_force_tog,
  input  logic          cfg_auto_arm,
  input  logic          cfg_dbl,
  input  logic [7:0]    cfg_maxp,
  input  logic          ev_in_tok,
  input  logic          ev_sof,
  input  logic          ev_ack,
  input  logic          ev_tx_done,
  input  logic          tx_rd,
  output logic          rsp_valid,
  output logic [2:0]    rsp_code,
  output logic [$clog2(DEPTH):0] tx_len,
  output logic [DW-1:0] tx_data,
  output logic          pkt_rdy,
  output logic          pkt_present,
  output logic          sent_stall,
  output logic          underrun,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [2:0] RSP_DATA0 = 3'd1;
  localparam logic [2:0] RSP_DATA1 = 3'd2;
  localparam logic [2:0] RSP_ZLP   = 3'd3;
  localparam logic [2:0] RSP_NAK   = 3'd4;
  localparam logic [2:0] RSP_STALL = 3'd5;

  logic [DW-1:0] mem [2*DEPTH];
  logic [LW-1:0] len_q [2];
  logic [1:0]    cnt;
  logic          wr_sel, rd_sel, tog, in_flight, sof_ok;
  logic [LW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  logic          full, wr_acc, auto_hit, do_arm, allow_tx, stall_now;
  logic          complete, dec, data_resp, underrun_set;
  logic [LW-1:0] ptr_after;
  logic [2:0]    code;

  assign full        = cnt >= (cfg_dbl ? 2'd2 : 2'd1);
  assign pkt_present = cnt != 2'd0;
  assign pkt_rdy     = full;
  assign wr_acc      = fw_wr_en & ~full & (wr_ptr < LW'(DEPTH));
  assign ptr_after   = wr_ptr + LW'(wr_acc);
  assign auto_hit    = wr_acc & cfg_auto_arm & (32'(ptr_after) == 32'({cfg_maxp, 3'b000}));
  assign do_arm      = (fw_arm | auto_hit) & ~full;
  assign allow_tx    = pkt_present & (~cfg_iso | ~cfg_wait_sof | sof_ok);
  assign stall_now   = ev_in_tok & ~cfg_iso & cfg_stall;
  assign complete    = in_flight & ((cfg_iso | cfg_force_tog) ? ev_tx_done : ev_ack);
  assign dec         = complete | (fw_flush & pkt_present);
  assign tx_len      = len_q[rd_sel];
  assign tx_data     = mem[{rd_sel, rd_ptr}];

  always_comb begin
    if (~cfg_iso & cfg_stall) code = RSP_STALL;
    else if (allow_tx)        code = (cfg_iso | ~tog) ? RSP_DATA0 : RSP_DATA1;
    else if (cfg_iso)         code = RSP_ZLP;
    else                      code = RSP_NAK;
  end

  assign data_resp    = ev_in_tok & ((code == RSP_DATA0) | (code == RSP_DATA1));
  assign underrun_set = ev_in_tok & ((code == RSP_NAK) | ((code == RSP_ZLP) & ~pkt_present));

  always_ff @(posedge clk)
    if (wr_acc) mem[{wr_sel, wr_ptr[AW-1:0]}] <= fw_wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; wr_sel <= 1'b0; rd_sel <= 1'b0; wr_ptr <= '0; rd_ptr <= '0;
      len_q[0] <= '0; len_q[1] <= '0;
      tog <= 1'b0; in_flight <= 1'b0; sof_ok <= 1'b0;
      rsp_valid <= 1'b0; rsp_code <= '0; irq <= 1'b0;
      sent_stall <= 1'b0; underrun <= 1'b0;
    end else begin
      rsp_valid  <= ev_in_tok;
      if (ev_in_tok) rsp_code <= code;
      irq        <= complete;
      sent_stall <= stall_now | (sent_stall & ~fw_clr_sent_stall);
      underrun   <= underrun_set | (underrun & ~fw_clr_underrun);
      if (fw_clr_tog)                tog <= 1'b0;
      else if (complete & ~cfg_iso)  tog <= ~tog;

      if (stall_now) begin
        cnt <= '0; wr_ptr <= '0; rd_ptr <= '0; wr_sel <= 1'b0; rd_sel <= 1'b0;
        in_flight <= 1'b0; sof_ok <= 1'b0;
      end else begin
        cnt <= cnt + {1'b0, do_arm} - {1'b0, dec};
        if (do_arm) begin
          len_q[wr_sel] <= ptr_after;
          wr_ptr <= '0;
          if (cfg_dbl) wr_sel <= ~wr_sel;
        end else if (fw_flush) wr_ptr <= '0;
        else                   wr_ptr <= ptr_after;

        if (dec) begin
          rd_ptr <= '0;
          if (cfg_dbl) rd_sel <= ~rd_sel;
        end else if (ev_in_tok) rd_ptr <= '0;
        else if (tx_rd)         rd_ptr <= rd_ptr + 1'b1;

        if (ev_in_tok) in_flight <= data_resp;
        else if (dec)  in_flight <= 1'b0;

        if (dec)                       sof_ok <= 1'b0;
        else if (ev_sof & pkt_present) sof_ok <= 1'b1;
      end
    end
  end

  AST_RSP_NEXT:    assert property (@(posedge clk) disable iff (!rst_n) ev_in_tok |=> rsp_valid); // R12
  AST_RSP_ONLY:    assert property (@(posedge clk) disable iff (!rst_n) !ev_in_tok |=> !rsp_valid); // R12
  AST_RDY_HELD:    assert property (@(posedge clk) disable iff (!rst_n) pkt_rdy |-> pkt_present); // R3
  AST_STALL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == RSP_STALL) |-> (!pkt_present && sent_stall)); // R6
  AST_NAK_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == RSP_NAK) |-> underrun); // R7
  AST_ISO_DATA0:   assert property (@(posedge clk) disable iff (!rst_n) (ev_in_tok && cfg_iso) |=> rsp_code != RSP_DATA1); // R11
  AST_IRQ_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R2
  AST_CNT_MAX:     assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2); // R5
endmodule

// File: tb/sim_usb_in_ep_buf.sv
module sim_usb_in_ep_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fw_wr_en = 0, fw_arm = 0, fw_flush = 0, fw_clr_tog = 0, fw_clr_sent_stall = 0, fw_clr_underrun = 0;
  logic [7:0] fw_wr_data = '0, cfg_maxp = 8'd1;
  logic cfg_stall = 0, cfg_iso = 0, cfg_wait_sof = 0, cfg_force_tog = 0, cfg_auto_arm = 0, cfg_dbl = 0;
  logic ev_in_tok = 0, ev_sof = 0, ev_ack = 0, ev_tx_done = 0, tx_rd = 0;
  logic rsp_valid, pkt_rdy, pkt_present, sent_stall, underrun, irq;
  logic [2:0] rsp_code;
  logic [6:0] tx_len;
  logic [7:0] tx_data;

  usb_in_ep_buf u0 (.*);

  always #5 clk = ~clk;

  typedef struct packed { logic [2:0] code; logic [6:0] len; logic [7:0] b0; } exp_t;
  exp_t  q[$];
  string tq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam int P_ARM = 0, P_FLUSH = 1, P_CLRTOG = 2, P_CLRSS = 3, P_CLRUR = 4,
                 P_SOF = 5, P_ACK = 6, P_TXD = 7;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic pulse(input int w);
    case (w)
      P_ARM:    fw_arm = 1;
      P_FLUSH:  fw_flush = 1;
      P_CLRTOG: fw_clr_tog = 1;
      P_CLRSS:  fw_clr_sent_stall = 1;
      P_CLRUR:  fw_clr_underrun = 1;
      P_SOF:    ev_sof = 1;
      P_ACK:    ev_ack = 1;
      default:  ev_tx_done = 1;
    endcase
    tick();
    {fw_arm, fw_flush, fw_clr_tog, fw_clr_sent_stall, fw_clr_underrun, ev_sof, ev_ack, ev_tx_done} = '0;
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      fw_wr_en = 1; fw_wr_data = base + 8'(i);
      tick();
    end
    fw_wr_en = 0;
  endtask

  task automatic in_tok(input logic [2:0] code, input int len, input logic [7:0] b0, input string tag);
    exp_t e;
    e.code = code; e.len = 7'(len); e.b0 = b0;
    q.push_back(e); tq.push_back(tag);
    ev_in_tok = 1; tick(); ev_in_tok = 0; tick();
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12 unexpected response actual=%0d expected=none", rsp_code);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front(); t = tq.pop_front();
        check({t, " R12 code"}, rsp_code, e.code);
        if (e.code == 3'd1 || e.code == 3'd2) begin
          check({t, " R2 tx_len"}, tx_len, e.len);
          check({t, " R2 first byte"}, tx_data, e.b0);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 pkt_rdy", pkt_rdy, 0);
    check("R1 pkt_present", pkt_present, 0);
    check("R1 sent_stall", sent_stall, 0);
    check("R1 underrun", underrun, 0);
    check("R1 irq", irq, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1; tick();

    in_tok(3'd4, 0, 0, "R7 bulk empty");
    check("R7 underrun set", underrun, 1);
    pulse(P_CLRUR);
    check("R7 underrun cleared", underrun, 0);

    load(5, 8'h10); pulse(P_ARM);
    check("R2 pkt_rdy after arm", pkt_rdy, 1);
    check("R2 present after arm", pkt_present, 1);
    in_tok(3'd1, 5, 8'h10, "R2 first send");
    in_tok(3'd1, 5, 8'h10, "R9 resend without ack");
    pulse(P_ACK);
    check("R2 irq after ack", irq, 1);
    check("R2 pkt_rdy after ack", pkt_rdy, 0);
    check("R2 present after ack", pkt_present, 0);
    tick();
    check("R2 irq one cycle", irq, 0);

    load(3, 8'h18); pulse(P_ARM);
    in_tok(3'd2, 3, 8'h18, "R9 toggle advanced");
    pulse(P_CLRTOG);
    in_tok(3'd1, 3, 8'h18, "R9 toggle cleared");
    pulse(P_ACK);

    cfg_dbl = 1;
    load(4, 8'h20); pulse(P_ARM);
    check("R3 first arm pkt_rdy", pkt_rdy, 0);
    check("R3 first arm present", pkt_present, 1);
    load(6, 8'h30); pulse(P_ARM);
    check("R3 second arm pkt_rdy", pkt_rdy, 1);
    in_tok(3'd2, 4, 8'h20, "R3 older first");
    pulse(P_ACK);
    check("R3 pkt_rdy after one done", pkt_rdy, 0);
    check("R3 still present", pkt_present, 1);
    check("R3 irq", irq, 1);
    in_tok(3'd1, 6, 8'h30, "R3 newer second");
    pulse(P_ACK);
    check("R3 empty", pkt_present, 0);

    load(2, 8'h40); pulse(P_ARM);
    load(3, 8'h50); pulse(P_ARM);
    pulse(P_FLUSH);
    check("R5 pkt_rdy after flush", pkt_rdy, 0);
    check("R5 present after one flush", pkt_present, 1);
    in_tok(3'd2, 3, 8'h50, "R5 older dropped");
    pulse(P_FLUSH);
    check("R5 empty after two flushes", pkt_present, 0);
    in_tok(3'd4, 0, 0, "R5 nothing left");
    pulse(P_CLRUR);

    cfg_dbl = 0; cfg_auto_arm = 1; cfg_maxp = 8'd1;
    load(7, 8'h60);
    check("R4 short not armed", pkt_present, 0);
    load(1, 8'h67);
    check("R4 auto armed present", pkt_present, 1);
    check("R4 auto armed pkt_rdy", pkt_rdy, 1);
    in_tok(3'd2, 8, 8'h60, "R4 auto packet");
    pulse(P_ACK);
    cfg_auto_arm = 0;

    cfg_force_tog = 1;
    load(2, 8'h70); pulse(P_ARM);
    in_tok(3'd1, 2, 8'h70, "R10 forced first");
    pulse(P_TXD);
    check("R10 irq without ack", irq, 1);
    check("R10 done without ack", pkt_present, 0);
    load(1, 8'h78); pulse(P_ARM);
    in_tok(3'd2, 1, 8'h78, "R10 forced flipped");
    pulse(P_TXD);
    cfg_force_tog = 0;

    load(3, 8'h80); pulse(P_ARM);
    cfg_stall = 1;
    in_tok(3'd5, 0, 0, "R6 stall");
    check("R6 sent_stall", sent_stall, 1);
    check("R6 flushed", pkt_present, 0);
    check("R6 pkt_rdy cleared", pkt_rdy, 0);
    pulse(P_CLRSS);
    check("R6 sent_stall cleared", sent_stall, 0);
    cfg_stall = 0;
    in_tok(3'd4, 0, 0, "R6 stall ended");
    pulse(P_CLRUR);

    cfg_iso = 1;
    load(2, 8'h90); pulse(P_ARM);
    in_tok(3'd1, 2, 8'h90, "R11 iso data0");
    pulse(P_TXD);
    check("R11 irq at tx_done", irq, 1);
    check("R11 completed", pkt_present, 0);
    in_tok(3'd3, 0, 0, "R7 iso empty zlp");
    check("R7 iso underrun", underrun, 1);
    pulse(P_CLRUR);
    cfg_wait_sof = 1;
    load(2, 8'hA0); pulse(P_ARM);
    in_tok(3'd3, 0, 0, "R8 before frame start");
    check("R8 no underrun while held", underrun, 0);
    check("R8 still held", pkt_present, 1);
    pulse(P_SOF);
    in_tok(3'd1, 2, 8'hA0, "R8 after frame start");
    pulse(P_TXD);
    check("R8 sent", pkt_present, 0);
    cfg_iso = 0; cfg_wait_sof = 0;

    load(1, 8'hB0); pulse(P_ARM);
    in_tok(3'd1, 1, 8'hB0, "R11 toggle untouched by iso");
    pulse(P_ACK);

    tick(); tick();
    check("R12 pending responses", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule